// File: doc/BRIEF.md
# Trace Exception Sequencer for Stop-Halt Instructions

This block sits next to an instruction retirement stage. It decides, one instruction at a time, whether a single-step trace exception must be requested. It also chooses the program counter value that goes into the exception frame. Most of the block handles the halt-and-load-status instruction (called STOP here). When tracing is active, this instruction needs a multi-step sequence. The instruction just before it traps, with the frame pointing at the STOP opcode. The handler then runs untraced. When the handler returns, STOP executes, loads the status register from its immediate, and traps a second time, with the frame pointing past STOP.

The block also covers the case where tracing is off and the STOP immediate turns it on. In that case the status register is loaded and a trace request is made straight away. When STOP leaves tracing off, the core simply halts. When another exception is taken in the same step as a completion, that exception wins and the trace request is dropped rather than queued.

Every output is registered. An input event seen at a rising clock edge shows up on the outputs after that edge.

Top module: `trace_seq`

## Requirements
- R1: After an active-low reset, trace_req_o, sr_load_o and halted_o are low, and frame_pc_o and sr_load_val_o are zero.
- R2: When a non-STOP instruction completes with sr_trace_i high and no other exception, trace_req_o is high in the following cycle and frame_pc_o holds that cycle's next_pc_i.
- R3: When a non-STOP instruction completes with sr_trace_i low, trace_req_o stays low.
- R4: Suppose the traced completion also has next_is_stop_i high. Then frame_pc_o is the STOP opcode address (next_pc_i). After that, completions raise neither trace_req_o nor sr_load_o until handler_ret_i has been seen.
- R5: Once handler_ret_i has been seen after a pre-STOP trace, the STOP completion drives sr_load_o and trace_req_o together in the following cycle. In that cycle sr_load_val_o equals stop_imm_i and frame_pc_o equals next_pc_i (the address after STOP). This holds even when the immediate clears the trace bit.
- R6: When tracing is off and a STOP completes whose immediate has bit 15 (the trace bit) set, sr_load_o and trace_req_o rise together, and frame_pc_o is the address after STOP.
- R7: When tracing is off and a STOP completes whose immediate has bit 15 clear, sr_load_o pulses, halted_o rises, and trace_req_o stays low.
- R8: When other_exc_i is high in the same cycle as a completion, no trace request results from that completion, and no pre-STOP sequence is entered.
- R9: halted_o drops in the cycle after the next non-STOP instruction completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| done_i | input | 1 | Instruction completion strobe |
| is_stop_i | input | 1 | The completing instruction is STOP |
| next_is_stop_i | input | 1 | The next instruction to run is STOP |
| other_exc_i | input | 1 | Another exception is taken this step |
| handler_ret_i | input | 1 | Trace handler return strobe |
| sr_trace_i | input | 1 | Current status register trace bit |
| stop_imm_i | input | 16 | STOP immediate operand |
| next_pc_i | input | 32 | Address of the instruction following the completing one |
| trace_req_o | output | 1 | Trace exception request pulse |
| frame_pc_o | output | 32 | PC value for the exception frame |
| sr_load_o | output | 1 | Status register load strobe |
| sr_load_val_o | output | 16 | Value loaded into the status register |
| halted_o | output | 1 | Core halted by STOP |

## Verification
The assertions assume that each input strobe, whether a completion or a handler return, is a single-cycle pulse. They also assume that next_pc_i and stop_imm_i are valid in the same cycle as the completion they belong to. Handler instructions are assumed to complete with the trace bit clear, which is how a real trap entry leaves it. The directed tasks drive every strobe for exactly one cycle, starting on a falling edge, with all qualifiers presented alongside. In the STOP sequence, the handler body's completion is given with the trace bit low.

// File: rtl/trace_seq_pkg.sv
package trace_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,  // pre-STOP trace taken, waiting for handler return
    ST_GO   = 2'd2   // handler returned, STOP may now execute
  } seq_state_e;
endpackage

// File: rtl/trace_seq_decide.sv
module trace_seq_decide
  import trace_seq_pkg::*;
#(
  parameter int SRW  = 16,
  parameter int TBIT = 15
) (
  input  seq_state_e       state_i,
  input  logic             done_i,
  input  logic             is_stop_i,
  input  logic             next_is_stop_i,
  input  logic             other_exc_i,
  input  logic             handler_ret_i,
  input  logic             sr_trace_i,
  input  logic [SRW-1:0]   stop_imm_i,
  output logic             fire_o,
  output logic             load_o,
  output logic             halt_set_o,
  output seq_state_e       state_d_o
);
  logic trace_cond;

  always_comb begin
    state_d_o  = state_i;
    fire_o     = 1'b0;
    load_o     = 1'b0;
    halt_set_o = 1'b0;
    trace_cond = 1'b0;
    unique case (state_i)
      ST_PRE: begin
        if (handler_ret_i) state_d_o = ST_GO;
      end
      default: begin
        if (done_i) begin
          if (is_stop_i) begin
            load_o     = 1'b1;
            trace_cond = (state_i == ST_GO) | sr_trace_i | stop_imm_i[TBIT];
            fire_o     = trace_cond & ~other_exc_i;
            halt_set_o = ~trace_cond;
            state_d_o  = ST_IDLE;
          end else begin
            fire_o    = sr_trace_i & ~other_exc_i;
            state_d_o = (sr_trace_i & next_is_stop_i & ~other_exc_i) ? ST_PRE : ST_IDLE;
          end
        end
      end
    endcase
  end
endmodule

// File: rtl/trace_seq_state.sv
module trace_seq_state
  import trace_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  seq_state_e state_d_i,
  output seq_state_e state_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q_o <= ST_IDLE;
    else         state_q_o <= state_d_i;
  end
endmodule

// File: rtl/trace_seq_out.sv
module trace_seq_out #(
  parameter int AW  = 32,
  parameter int SRW = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           fire_i,
  input  logic           load_i,
  input  logic           halt_set_i,
  input  logic           done_i,
  input  logic [AW-1:0]  next_pc_i,
  input  logic [SRW-1:0] stop_imm_i,
  output logic           trace_req_o,
  output logic [AW-1:0]  frame_pc_o,
  output logic           sr_load_o,
  output logic [SRW-1:0] sr_load_val_o,
  output logic           halted_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trace_req_o   <= 1'b0;
      frame_pc_o    <= '0;
      sr_load_o     <= 1'b0;
      sr_load_val_o <= '0;
      halted_o      <= 1'b0;
    end else begin
      trace_req_o <= fire_i;
      sr_load_o   <= load_i;
      if (fire_i) frame_pc_o    <= next_pc_i;
      if (load_i) sr_load_val_o <= stop_imm_i;
      if (halt_set_i)  halted_o <= 1'b1;
      else if (done_i) halted_o <= 1'b0;
    end
  end
endmodule

// File: rtl/trace_seq.sv
module trace_seq
  import trace_seq_pkg::*;
#(
  parameter int AW   = 32,
  parameter int SRW  = 16,
  parameter int TBIT = 15
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           done_i,
  input  logic           is_stop_i,
  input  logic           next_is_stop_i,
  input  logic           other_exc_i,
  input  logic           handler_ret_i,
  input  logic           sr_trace_i,
  input  logic [SRW-1:0] stop_imm_i,
  input  logic [AW-1:0]  next_pc_i,
  output logic           trace_req_o,
  output logic [AW-1:0]  frame_pc_o,
  output logic           sr_load_o,
  output logic [SRW-1:0] sr_load_val_o,
  output logic           halted_o
);
  seq_state_e state_q, state_d;
  logic fire, load, halt_set;

  trace_seq_decide #(.SRW(SRW), .TBIT(TBIT)) u_decide (
    .state_i(state_q), .done_i(done_i), .is_stop_i(is_stop_i),
    .next_is_stop_i(next_is_stop_i), .other_exc_i(other_exc_i),
    .handler_ret_i(handler_ret_i), .sr_trace_i(sr_trace_i),
    .stop_imm_i(stop_imm_i), .fire_o(fire), .load_o(load),
    .halt_set_o(halt_set), .state_d_o(state_d)
  );

  trace_seq_state u_state (
    .clk_i(clk_i), .rst_ni(rst_ni), .state_d_i(state_d), .state_q_o(state_q)
  );

  trace_seq_out #(.AW(AW), .SRW(SRW)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .fire_i(fire), .load_i(load),
    .halt_set_i(halt_set), .done_i(done_i), .next_pc_i(next_pc_i),
    .stop_imm_i(stop_imm_i), .trace_req_o(trace_req_o),
    .frame_pc_o(frame_pc_o), .sr_load_o(sr_load_o),
    .sr_load_val_o(sr_load_val_o), .halted_o(halted_o)
  );

  a_r2_trace_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_PRE && done_i && !is_stop_i && sr_trace_i && !other_exc_i)
    |=> (trace_req_o && frame_pc_o == $past(next_pc_i)));

  a_r3_no_trace_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_PRE && done_i && !is_stop_i && !sr_trace_i) |=> !trace_req_o);

  a_r4_quiet_before_return: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PRE && done_i) |=> (!trace_req_o && !sr_load_o));

  a_r5_stop_after_return: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GO && done_i && is_stop_i && !other_exc_i)
    |=> (trace_req_o && sr_load_o && sr_load_val_o == $past(stop_imm_i)
         && frame_pc_o == $past(next_pc_i)));

  a_r6_stop_enables_trace: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && done_i && is_stop_i && !sr_trace_i && stop_imm_i[TBIT]
     && !other_exc_i) |=> (trace_req_o && sr_load_o));

  a_r7_stop_halts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && done_i && is_stop_i && !sr_trace_i && !stop_imm_i[TBIT])
    |=> (halted_o && sr_load_o && !trace_req_o));

  a_r8_exc_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && other_exc_i) |=> !trace_req_o);

  a_r9_halt_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_o && done_i && !is_stop_i) |=> !halted_o);
endmodule

// File: tb/trace_seq_test.sv
`timescale 1ns/1ps
module trace_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        done = 1'b0, is_stop = 1'b0, next_stop = 1'b0, oexc = 1'b0, hret = 1'b0;
  logic        tbit = 1'b0;
  logic [15:0] imm = '0;
  logic [31:0] npc = '0;
  logic        treq, sload, halted;
  logic [31:0] fpc;
  logic [15:0] sval;
  int nchk = 0, nfail = 0;

  always #2 clk = ~clk;

  trace_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .done_i(done), .is_stop_i(is_stop),
    .next_is_stop_i(next_stop), .other_exc_i(oexc), .handler_ret_i(hret),
    .sr_trace_i(tbit), .stop_imm_i(imm), .next_pc_i(npc),
    .trace_req_o(treq), .frame_pc_o(fpc), .sr_load_o(sload),
    .sr_load_val_o(sval), .halted_o(halted)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one-cycle stimulus from a falling edge; outputs checked at the next falling edge
  task automatic step(input logic d, input logic s, input logic ns, input logic t,
                      input logic [15:0] im, input logic [31:0] pc, input logic ex, input logic hr);
    done = d; is_stop = s; next_stop = ns; tbit = t; imm = im; npc = pc; oexc = ex; hret = hr;
    @(negedge clk);
    done = 0; is_stop = 0; next_stop = 0; oexc = 0; hret = 0;
  endtask

  task automatic t_reset;
    chk(!treq, "R1 trace_req", 32'(treq), 0);
    chk(!sload && !halted, "R1 load/halt", {30'd0, sload, halted}, 0);
    chk(fpc == 0 && sval == 0, "R1 frame/val", fpc, 0);
  endtask

  task automatic t_plain_trace;
    step(1, 0, 0, 1, 16'h0, 32'h1000, 0, 0);
    chk(treq, "R2 req", 32'(treq), 1);
    chk(fpc == 32'h1000, "R2 pc", fpc, 32'h1000);
    step(1, 0, 0, 1, 16'h0, 32'h1002, 0, 0);
    chk(treq && fpc == 32'h1002, "R2 back-to-back", fpc, 32'h1002);
  endtask

  task automatic t_trace_off;
    step(1, 0, 0, 0, 16'h0, 32'h2000, 0, 0);
    chk(!treq, "R3 req", 32'(treq), 0);
    chk(fpc == 32'h1002, "R3 frame held", fpc, 32'h1002);
  endtask

  task automatic t_stop_seq;
    step(1, 0, 1, 1, 16'h0, 32'h3000, 0, 0);
    chk(treq && fpc == 32'h3000, "R4 pc at STOP", fpc, 32'h3000);
    step(1, 0, 0, 0, 16'h0, 32'h9000, 0, 0);   // handler body, untraced
    chk(!treq && !sload, "R4 quiet", {30'd0, treq, sload}, 0);
    step(1, 1, 0, 1, 16'h2700, 32'h9100, 0, 0); // STOP-like before return: held off
    chk(!treq && !sload, "R4 held", {30'd0, treq, sload}, 0);
    step(0, 0, 0, 0, 16'h0, 32'h0, 0, 1);
    chk(!treq && !sload, "R4 return", {30'd0, treq, sload}, 0);
    step(1, 1, 0, 1, 16'h2700, 32'h3004, 0, 0);
    chk(treq && sload, "R5 req+load", {30'd0, treq, sload}, 3);
    chk(sval == 16'h2700, "R5 sr value", 32'(sval), 32'h2700);
    chk(fpc == 32'h3004, "R5 pc after STOP", fpc, 32'h3004);
    chk(!halted, "R5 not halted", 32'(halted), 0);
  endtask

  task automatic t_stop_enables;
    step(1, 1, 0, 0, 16'hA700, 32'h4004, 0, 0);
    chk(treq && sload, "R6 req+load", {30'd0, treq, sload}, 3);
    chk(fpc == 32'h4004 && sval == 16'hA700, "R6 pc", fpc, 32'h4004);
  endtask

  task automatic t_stop_halt;
    step(1, 1, 0, 0, 16'h2000, 32'h5004, 0, 0);
    chk(sload && sval == 16'h2000, "R7 load", 32'(sval), 32'h2000);
    chk(halted && !treq, "R7 halt", {30'd0, halted, treq}, 2);
    step(0, 0, 0, 0, 16'h0, 32'h0, 0, 0);
    chk(halted && !sload, "R7 halt held", {30'd0, halted, sload}, 2);
    step(1, 0, 0, 0, 16'h0, 32'h6000, 0, 0);
    chk(!halted, "R9 cleared", 32'(halted), 0);
  endtask

  task automatic t_other_exc;
    step(1, 0, 1, 1, 16'h0, 32'h7000, 1, 0);
    chk(!treq, "R8 suppressed", 32'(treq), 0);
    step(1, 0, 0, 1, 16'h0, 32'h7010, 0, 0); // would be ignored if pre-STOP had been entered
    chk(treq && fpc == 32'h7010, "R8 no pre-STOP", fpc, 32'h7010);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_plain_trace();
    t_trace_off();
    t_stop_seq();
    t_stop_enables();
    t_stop_halt();
    t_other_exc();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #20000;
    nchk++; nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule